// File: doc/BRIEF.md
# Sleep State and Power-Button Controller

This block holds the system power state (S0 running; S1, S3, S4 and S5 sleeping) and drives one active-low control line per power plane. The lines are cumulative: each deeper state keeps every line that a shallower sleep state already pulls low. All timing is counted in ticks of a slow, always-on clock, and every input that arrives from a pin is synchronized before use.

Software asks for a sleep state through a one-cycle request port. The block first pulls a suspend-status warning low, holds it for a fixed number of ticks, and only then switches the plane lines. The debounced power button does two jobs. A press while running produces a one-tick sleep-request pulse for software. A press while asleep wakes the system. If the button is held long enough, the block forces soft-off from any state.

A thermal trip forces soft-off at once and skips the warning. A low battery blocks every wake. A ring input can wake the system when its enable bit is set. That bit is cleared only by the always-on reset, so it is kept through every sleep state and through soft-off.

Top module: `sleepStateCtl`

## Requirements
- R1: State codes on `pwrState` are S0=0, S1=1, S3=3, S4=4, S5=5. `slpS1N` is low in every code other than 0. `slpS3N` is low for codes 3 and above. `slpS4N` is low for codes 4 and above. `slpS5N` is low only for code 5.
- R2: In S0, a `reqValid` pulse with `reqState` equal to 1, 3, 4 or 5 drives `susStatN` low from the next tick. The plane lines and `pwrState` keep their S0 values for WARN_TICKS further ticks and then take the requested code. Any other code is ignored. `susStatN` stays low whenever `pwrState` is not 0.
- R3: A request that arrives while the block is asleep, or during the warning period, has no effect.
- R4: A debounced button press in S0 gives exactly one single-tick pulse on `sleepReq` and leaves the state at S0.
- R5: A debounced button press while asleep returns the block to S0 and releases `susStatN` (high).
- R6: A button low pulse shorter than DEBOUNCE_TICKS ticks after synchronization is not counted as a press.
- R7: Holding the debounced button for OVERRIDE_TICKS ticks forces S5 from any state. Releasing the button clears the hold count, so two shorter holds never add up to an override.
- R8: After an override, the ring input cannot wake the block; only a button press can. The next return to S0 lifts this restriction.
- R9: A low `thermTripN` forces S5 directly, with no warning period. It takes priority over a software request made in the same tick, and the block does not wake while the trip is held.
- R10: While `batLowN` is low, neither the button nor the ring input wakes the block.
- R11: When the ring enable bit (written through `ringEnWr`/`ringEnIn`) is 1, a low `ringN` wakes the block from sleep; when it is 0, the ring input is ignored. The bit is cleared only by `rstN` and is kept through sleep states and S5.
- R12: After reset the block is in S0, all plane lines and `susStatN` are high, `sleepReq` is low and the ring enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on tick clock |
| rstN | input | 1 | Always-on-domain reset, active low, asynchronous |
| reqValid | input | 1 | One-tick software sleep request strobe |
| reqState | input | 3 | Requested state code (1, 3, 4 or 5) |
| ringEnWr | input | 1 | Write strobe for the ring wake enable bit |
| ringEnIn | input | 1 | Value written to the ring wake enable bit |
| pwrBtnN | input | 1 | Raw power button, low when pressed |
| thermTripN | input | 1 | Thermal trip, low when tripped |
| batLowN | input | 1 | Battery low indication, active low |
| ringN | input | 1 | Ring indicate wake input, active low |
| slpS1N | output | 1 | Plane control, low in S1 and deeper |
| slpS3N | output | 1 | Plane control, low in S3 and deeper |
| slpS4N | output | 1 | Plane control, low in S4 and S5 |
| slpS5N | output | 1 | Plane control, low only in S5 |
| susStatN | output | 1 | Suspend status warning, active low |
| sleepReq | output | 1 | One-tick pulse: button pressed while running |
| pwrState | output | 3 | Current state code |

## Verification
Two events can fall in the same tick. A software sleep request and a thermal trip are driven together; the request starts a warning, and two ticks later the synchronized trip overrides it. The bench judges the result by seeing S5 with all four plane lines low well before a warning could have finished, and by seeing no wake while the trip is held. A second overlap is a held button whose press wakes the block and whose continued hold then forces S5. The bench checks this by sampling S5 while the button is still held.

// File: rtl/sleepPkg.sv
package sleepPkg;

  typedef enum logic [2:0] {
    PS_S0 = 3'd0,
    PS_S1 = 3'd1,
    PS_S3 = 3'd3,
    PS_S4 = 3'd4,
    PS_S5 = 3'd5
  } pwrStateE;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_WARN   = 2'd1,
    MODE_ASLEEP = 2'd2
  } ctlModeE;

  // strobes from control into the datapath
  typedef struct packed {
    logic warnStart;
    logic warnRun;
  } ctlStrobeT;

endpackage

// File: rtl/sleepDatapath.sv
module sleepDatapath
  import sleepPkg::*;
#(
  parameter int DEBOUNCE_TICKS = 524,
  parameter int OVERRIDE_TICKS = 131072,
  parameter int WARN_TICKS     = 32,
  parameter int SYNC_STAGES    = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pwrBtnN,
  input  logic      thermTripN,
  input  logic      batLowN,
  input  logic      ringN,
  input  logic      ringEnWr,
  input  logic      ringEnIn,
  input  ctlStrobeT strobe,
  output logic      pressEvt,
  output logic      overrideHit,
  output logic      tripActive,
  output logic      batLowActive,
  output logic      ringActive,
  output logic      ringEn,
  output logic      warnDone
);

  localparam int NUM_IN = 4;
  localparam int DBW = $clog2(DEBOUNCE_TICKS + 1);
  localparam int OVW = $clog2(OVERRIDE_TICKS + 1);
  localparam int WNW = $clog2(WARN_TICKS + 1);
  localparam logic [DBW-1:0] DB_LAST = DBW'(DEBOUNCE_TICKS - 1);
  localparam logic [OVW-1:0] OV_HIT  = OVW'(OVERRIDE_TICKS - 1);
  localparam logic [OVW-1:0] OV_MAX  = OVW'(OVERRIDE_TICKS);
  localparam logic [WNW-1:0] WN_LAST = WNW'(WARN_TICKS - 1);

  // bit 0 button, 1 trip, 2 battery low, 3 ring; all active high here
  logic [NUM_IN-1:0] rawActive;
  logic [NUM_IN-1:0] syncOut;
  assign rawActive = ~{ringN, batLowN, thermTripN, pwrBtnN};

  for (genvar i = 0; i < NUM_IN; i++) begin : gSync
    logic [SYNC_STAGES-1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= '0;
      else       stage <= {stage[SYNC_STAGES-2:0], rawActive[i]};
    end
    assign syncOut[i] = stage[SYNC_STAGES-1];
  end

  assign tripActive   = syncOut[1];
  assign batLowActive = syncOut[2];
  assign ringActive   = syncOut[3];

  // button debounce: level must differ for DEBOUNCE_TICKS ticks in a row
  logic           btnStable;
  logic           btnStablePrev;
  logic [DBW-1:0] dbCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      btnStable     <= 1'b0;
      btnStablePrev <= 1'b0;
      dbCnt         <= '0;
    end else begin
      btnStablePrev <= btnStable;
      if (syncOut[0] == btnStable) begin
        dbCnt <= '0;
      end else if (dbCnt == DB_LAST) begin
        btnStable <= syncOut[0];
        dbCnt     <= '0;
      end else begin
        dbCnt <= dbCnt + 1'b1;
      end
    end
  end

  assign pressEvt = btnStable & ~btnStablePrev;

  // hold counter for the long-press override, cleared on release
  logic [OVW-1:0] ovCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ovCnt <= '0;
    else if (!btnStable)      ovCnt <= '0;
    else if (ovCnt != OV_MAX) ovCnt <= ovCnt + 1'b1;
  end

  assign overrideHit = btnStable && (ovCnt == OV_HIT);

  // suspend-status lead time
  logic [WNW-1:0] wnCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   wnCnt <= '0;
    else if (strobe.warnStart)                   wnCnt <= '0;
    else if (strobe.warnRun && wnCnt != WN_LAST) wnCnt <= wnCnt + 1'b1;
  end

  assign warnDone = strobe.warnRun && (wnCnt == WN_LAST);

  // ring wake enable, cleared only by the always-on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ringEn <= 1'b0;
    else if (ringEnWr) ringEn <= ringEnIn;
  end

endmodule

// File: rtl/sleepControl.sv
module sleepControl
  import sleepPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic [2:0] reqState,
  input  logic      pressEvt,
  input  logic      overrideHit,
  input  logic      tripActive,
  input  logic      batLowActive,
  input  logic      ringActive,
  input  logic      ringEn,
  input  logic      warnDone,
  output ctlStrobeT strobe,
  output pwrStateE  curState,
  output logic      susStatN,
  output logic      sleepReq
);

  ctlModeE  mode, modeNext;
  pwrStateE stateNext, target, targetNext;
  logic     btnOnly, btnOnlyNext;
  logic     reqPulse;
  logic     reqOk;
  logic     wakeSrc;

  assign reqOk   = reqState inside {3'd1, 3'd3, 3'd4, 3'd5};
  assign wakeSrc = pressEvt || (ringActive && ringEn && !btnOnly);

  always_comb begin
    modeNext         = mode;
    stateNext        = curState;
    targetNext       = target;
    btnOnlyNext      = btnOnly;
    reqPulse         = 1'b0;
    strobe.warnStart = 1'b0;
    strobe.warnRun   = (mode == MODE_WARN);
    if (tripActive) begin
      modeNext  = MODE_ASLEEP;
      stateNext = PS_S5;
    end else if (overrideHit) begin
      modeNext    = MODE_ASLEEP;
      stateNext   = PS_S5;
      btnOnlyNext = 1'b1;
    end else begin
      unique case (mode)
        MODE_RUN: begin
          if (reqValid && reqOk) begin
            modeNext         = MODE_WARN;
            targetNext       = pwrStateE'(reqState);
            strobe.warnStart = 1'b1;
          end else if (pressEvt) begin
            reqPulse = 1'b1;
          end
        end
        MODE_WARN: begin
          if (warnDone) begin
            modeNext  = MODE_ASLEEP;
            stateNext = target;
          end
        end
        MODE_ASLEEP: begin
          if (!batLowActive && wakeSrc) begin
            modeNext    = MODE_RUN;
            stateNext   = PS_S0;
            btnOnlyNext = 1'b0;
          end
        end
        default: modeNext = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_RUN;
      curState <= PS_S0;
      target   <= PS_S0;
      btnOnly  <= 1'b0;
      sleepReq <= 1'b0;
    end else begin
      mode     <= modeNext;
      curState <= stateNext;
      target   <= targetNext;
      btnOnly  <= btnOnlyNext;
      sleepReq <= reqPulse;
    end
  end

  assign susStatN = (mode == MODE_RUN);

endmodule

// File: rtl/sleepPlaneDecode.sv
module sleepPlaneDecode
  import sleepPkg::*;
#(
  parameter int NUM_PLANES = 4
) (
  input  pwrStateE              curState,
  output logic [NUM_PLANES-1:0] slpN
);

  // depth at which each plane line goes low: S1, S3, S4, S5
  localparam logic [2:0] THRESH [NUM_PLANES] = '{3'd1, 3'd3, 3'd4, 3'd5};

  for (genvar i = 0; i < NUM_PLANES; i++) begin : gPlane
    assign slpN[i] = !(3'(curState) >= THRESH[i]);
  end

endmodule

// File: rtl/sleepStateCtl.sv
module sleepStateCtl
  import sleepPkg::*;
#(
  parameter int DEBOUNCE_TICKS = 524,
  parameter int OVERRIDE_TICKS = 131072,
  parameter int WARN_TICKS     = 32,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqState,
  input  logic       ringEnWr,
  input  logic       ringEnIn,
  input  logic       pwrBtnN,
  input  logic       thermTripN,
  input  logic       batLowN,
  input  logic       ringN,
  output logic       slpS1N,
  output logic       slpS3N,
  output logic       slpS4N,
  output logic       slpS5N,
  output logic       susStatN,
  output logic       sleepReq,
  output logic [2:0] pwrState
);

  ctlStrobeT strobe;
  pwrStateE  curState;
  logic      pressEvt, overrideHit, tripActive, batLowActive;
  logic      ringActive, ringEn, warnDone;
  logic [3:0] slpN;

  sleepDatapath #(
    .DEBOUNCE_TICKS(DEBOUNCE_TICKS),
    .OVERRIDE_TICKS(OVERRIDE_TICKS),
    .WARN_TICKS    (WARN_TICKS),
    .SYNC_STAGES   (SYNC_STAGES)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .pwrBtnN     (pwrBtnN),
    .thermTripN  (thermTripN),
    .batLowN     (batLowN),
    .ringN       (ringN),
    .ringEnWr    (ringEnWr),
    .ringEnIn    (ringEnIn),
    .strobe      (strobe),
    .pressEvt    (pressEvt),
    .overrideHit (overrideHit),
    .tripActive  (tripActive),
    .batLowActive(batLowActive),
    .ringActive  (ringActive),
    .ringEn      (ringEn),
    .warnDone    (warnDone)
  );

  sleepControl uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqState    (reqState),
    .pressEvt    (pressEvt),
    .overrideHit (overrideHit),
    .tripActive  (tripActive),
    .batLowActive(batLowActive),
    .ringActive  (ringActive),
    .ringEn      (ringEn),
    .warnDone    (warnDone),
    .strobe      (strobe),
    .curState    (curState),
    .susStatN    (susStatN),
    .sleepReq    (sleepReq)
  );

  sleepPlaneDecode #(.NUM_PLANES(4)) uDec (
    .curState(curState),
    .slpN    (slpN)
  );

  assign slpS1N   = slpN[0];
  assign slpS3N   = slpN[1];
  assign slpS4N   = slpN[2];
  assign slpS5N   = slpN[3];
  assign pwrState = 3'(curState);

endmodule

// File: rtl/sleepStateCtlChk.sv
module sleepStateCtlChk (
  input logic       clk,
  input logic       rstN,
  input logic       slpS1N,
  input logic       slpS3N,
  input logic       slpS4N,
  input logic       slpS5N,
  input logic       susStatN,
  input logic       sleepReq,
  input logic [2:0] pwrState,
  input logic       tripActive,
  input logic       batLowActive
);

  AST_PLANE_NESTING: assert property (@(posedge clk) disable iff (!rstN)
    (!slpS5N |-> !slpS4N) and (!slpS4N |-> !slpS3N) and (!slpS3N |-> !slpS1N)); // R1

  AST_SUS_WHILE_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 3'd0) |-> !susStatN); // R2

  AST_WARN_LEADS_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(slpS1N) && pwrState != 3'd5) |-> $past(!susStatN)); // R2

  AST_REQ_SINGLE_TICK: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> !sleepReq); // R4

  AST_TRIP_SOFT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    tripActive |=> (pwrState == 3'd5)); // R9

  AST_BATLOW_HOLDS_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (batLowActive && pwrState != 3'd0) |=> (pwrState != 3'd0)); // R10

endmodule

bind sleepStateCtl sleepStateCtlChk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .slpS1N      (slpS1N),
  .slpS3N      (slpS3N),
  .slpS4N      (slpS4N),
  .slpS5N      (slpS5N),
  .susStatN    (susStatN),
  .sleepReq    (sleepReq),
  .pwrState    (pwrState),
  .tripActive  (tripActive),
  .batLowActive(batLowActive)
);

// File: tb/sim_sleepStateCtl.sv
module sim_sleepStateCtl;

  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 4;
  localparam int OVR  = 40;
  localparam int WARN = 5;

  typedef struct packed {
    logic [2:0] req;
    logic [2:0] expState;
    logic [3:0] expPlanes; // {slpS5N, slpS4N, slpS3N, slpS1N}
  } vecT;

  localparam vecT VEC [6] = '{
    '{3'd1, 3'd1, 4'b1110},
    '{3'd3, 3'd3, 4'b1100},
    '{3'd4, 3'd4, 4'b1000},
    '{3'd5, 3'd5, 4'b0000},
    '{3'd2, 3'd0, 4'b1111},
    '{3'd7, 3'd0, 4'b1111}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqState = 3'd0;
  logic ringEnWr = 1'b0, ringEnIn = 1'b0;
  logic pwrBtnN = 1'b1, thermTripN = 1'b1, batLowN = 1'b1, ringN = 1'b1;
  logic slpS1N, slpS3N, slpS4N, slpS5N, susStatN, sleepReq;
  logic [2:0] pwrState;

  int checks = 0;
  int fails = 0;
  int reqPulses = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sleepStateCtl #(
    .DEBOUNCE_TICKS(DEB),
    .OVERRIDE_TICKS(OVR),
    .WARN_TICKS    (WARN),
    .SYNC_STAGES   (2)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqState(reqState),
    .ringEnWr(ringEnWr), .ringEnIn(ringEnIn), .pwrBtnN(pwrBtnN),
    .thermTripN(thermTripN), .batLowN(batLowN), .ringN(ringN),
    .slpS1N(slpS1N), .slpS3N(slpS3N), .slpS4N(slpS4N), .slpS5N(slpS5N),
    .susStatN(susStatN), .sleepReq(sleepReq), .pwrState(pwrState)
  );

  always @(posedge clk) if (rstN && sleepReq) reqPulses <= reqPulses + 1;

  function automatic logic [3:0] planes();
    return {slpS5N, slpS4N, slpS3N, slpS1N};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag, input int exp);
    chk(pwrState == exp, tag, pwrState, exp);
  endtask

  task automatic chkPlanes(input string tag, input logic [3:0] exp);
    chk(planes() == exp, tag, planes(), exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pressBtn(input int hold);
    pwrBtnN = 1'b0;
    tick(hold);
    pwrBtnN = 1'b1;
    tick(DEB + 6);
  endtask

  task automatic sendReq(input logic [2:0] code);
    reqValid = 1'b1;
    reqState = code;
    tick(1);
    reqValid = 1'b0;
  endtask

  task automatic goSleep(input logic [2:0] code);
    sendReq(code);
    tick(WARN + 1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);

    // R12 reset state
    chkState("R12 state after reset", 0);
    chkPlanes("R12 planes after reset", 4'b1111);
    chk(susStatN == 1'b1, "R12 susStatN after reset", susStatN, 1);
    chk(sleepReq == 1'b0, "R12 sleepReq after reset", sleepReq, 0);
    // ring enable defaults to 0: sleep, ring low, no wake
    goSleep(3'd1);
    ringN = 1'b0;
    tick(5);
    chkState("R12 ring enable clear after reset", 1);
    ringN = 1'b1;
    pressBtn(DEB + 6);

    // table walk: R1 / R2 / R5
    for (int i = 0; i < 6; i++) begin
      sendReq(VEC[i].req);
      if (VEC[i].expState != 3'd0) begin
        chk(susStatN == 1'b0, "R2 warning asserted", susStatN, 0);
        chkPlanes("R2 planes held during warning", 4'b1111);
        tick(WARN - 1);
        chkPlanes("R2 planes still held at end of warning", 4'b1111);
        tick(1);
        chkState("R1 state code", VEC[i].expState);
        chkPlanes("R1 plane encoding", VEC[i].expPlanes);
        chk(susStatN == 1'b0, "R2 susStatN low while asleep", susStatN, 0);
        pressBtn(DEB + 6);
        chkState("R5 button wake", 0);
        chk(susStatN == 1'b1, "R5 susStatN released", susStatN, 1);
      end else begin
        tick(WARN + 1);
        chk(susStatN == 1'b1, "R2 invalid code ignored (status)", susStatN, 1);
        chkState("R2 invalid code ignored (state)", 0);
      end
    end
    chk(reqPulses == 0, "R4 no sleepReq on wake presses", reqPulses, 0);

    // R3 request while asleep and during warning
    goSleep(3'd3);
    sendReq(3'd1);
    tick(WARN + 2);
    chkState("R3 request ignored while asleep", 3);
    pressBtn(DEB + 6);
    sendReq(3'd4);
    tick(1);
    sendReq(3'd1);
    tick(WARN + 2);
    chkState("R3 request ignored during warning", 4);
    pressBtn(DEB + 6);

    // R4 press while running
    pressBtn(DEB + 6);
    chk(reqPulses == 1, "R4 single sleepReq pulse", reqPulses, 1);
    chkState("R4 state unchanged", 0);

    // R6 glitch shorter than debounce
    goSleep(3'd3);
    pressBtn(DEB - 2);
    chkState("R6 short glitch ignored", 3);
    pressBtn(DEB + 6);
    chkState("R6 real press still wakes", 0);

    // R7 / R8 override from S0, ring enabled
    ringEnWr = 1'b1; ringEnIn = 1'b1;
    tick(1);
    ringEnWr = 1'b0;
    pwrBtnN = 1'b0;
    tick(DEB + OVR + 8);
    chkState("R7 override forces S5 from S0", 5);
    chkPlanes("R7 planes in override S5", 4'b0000);
    pwrBtnN = 1'b1;
    tick(DEB + 6);
    ringN = 1'b0;
    tick(5);
    chkState("R8 ring ignored after override", 5);
    ringN = 1'b1;
    tick(2);
    pressBtn(DEB + 6);
    chkState("R8 button wakes after override", 0);

    // R7 release clears the hold count
    pressBtn(30);
    pressBtn(30);
    chkState("R7 two short holds no override", 0);

    // R7 override from a sleep state (press wakes, hold forces S5)
    goSleep(3'd3);
    pwrBtnN = 1'b0;
    tick(DEB + OVR + 8);
    chkState("R7 override forces S5 from S3", 5);
    pwrBtnN = 1'b1;
    tick(DEB + 6);
    pressBtn(DEB + 6);
    chkState("R7 wake after override", 0);

    // R9 thermal trip together with a software request
    reqValid = 1'b1;
    reqState = 3'd1;
    thermTripN = 1'b0;
    tick(1);
    reqValid = 1'b0;
    tick(3);
    chkState("R9 trip beats request", 5);
    chkPlanes("R9 planes after trip", 4'b0000);
    pressBtn(DEB + 6);
    chkState("R9 no wake while trip held", 5);
    thermTripN = 1'b1;
    tick(3);
    pressBtn(DEB + 6);
    chkState("R9 wake after trip released", 0);

    // R10 battery low blocks wake; R11 ring enable kept through S5
    goSleep(3'd1);
    batLowN = 1'b0;
    tick(3);
    pressBtn(DEB + 6);
    chkState("R10 button blocked by battery low", 1);
    ringN = 1'b0;
    tick(5);
    chkState("R10 ring blocked by battery low", 1);
    batLowN = 1'b1;
    tick(5);
    chkState("R11 ring wakes, enable kept through S5", 0);
    ringN = 1'b1;
    tick(3);

    // R11 ring disabled
    ringEnWr = 1'b1; ringEnIn = 1'b0;
    tick(1);
    ringEnWr = 1'b0;
    goSleep(3'd3);
    ringN = 1'b0;
    tick(6);
    chkState("R11 ring ignored when disabled", 3);
    ringN = 1'b1;
    pressBtn(DEB + 6);
    chkState("R11 button wake after disabled ring", 0);

    finish();
  end

endmodule